// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on the write side of an 8-bit CPU bus with a 16-bit address and turns stores into the read-only region into bank settings. It combines those settings with the live CPU address to form a physical ROM address for both 16 KiB ROM windows. It also forms a physical RAM address and a chip select for the 8 KiB external RAM window at 0xA000-0xBFFF. The ROM and RAM arrays themselves are outside the block.

It also keeps a small real-time clock with seconds, minutes, hours and a 9-bit day count, advanced by a one-per-second tick input. Software reads the clock through five latched registers. These are mapped into the external RAM window when the shared select register holds a clock-register code. A write of 0 followed by a write of 1 to the latch region copies the running counters into the latched set.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write to 0x0000-0x1FFF with data 0x0A enables external RAM and data 0x00 disables it. Every other data value leaves the enable as it was.
- R2: A write to 0x2000-0x3FFF loads the ROM bank from data[6:0], with a value of 0 replaced by 1. The result is then ANDed with ROM_BANKS-1, so with 32 banks a write of 0x20 gives bank 0.
- R3: A write to 0x4000-0x5FFF with data 0..3 selects that RAM bank and turns clock mode off. Data 0x04-0x07 and 0x0D-0xFF change nothing.
- R4: A write to 0x4000-0x5FFF with data 0x08..0x0C turns clock mode on and selects clock register data-8.
- R5: A write of 1 to 0x6000-0x7FFF copies the live counters into the latched registers only when the previous write to that region carried 0. Any other write there latches nothing.
- R6: rom_addr_o = {bank, addr_i[13:0]}, where bank is 0 for addr_i in 0x0000-0x3FFF and the selected ROM bank for 0x4000-0x7FFF.
- R7: In the window 0xA000-0xBFFF, ram_cs_o is 1 only when RAM is enabled and clock mode is off. ram_addr_o = {ram bank, addr_i[12:0]}. In clock mode ext_rdata_o is the selected latched register; otherwise it is 0xFF.
- R8: Clock register 0 holds seconds, 1 minutes, 2 hours and 3 the day count bits 7:0. In register 4, bit 0 is day bit 8 and bits 7:1 keep their last written value across a latch.
- R9: On each tick the seconds wrap 59 to 0 and carry into the minutes, which wrap 59 to 0 and carry into the hours. The hours wrap 23 to 0 and carry into the day count, which wraps 511 to 0.
- R10: In clock mode, a write into 0xA000-0xBFFF stores the data byte in the selected latched register and loads the matching live counter field. Register 4 bit 0 loads day bit 8. Such a write takes priority over a tick in the same cycle.
- R11: After reset the ROM bank is 1, the RAM bank is 0, RAM is disabled, clock mode is off, no latch is armed, and all counters and latched registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | 16 | CPU bus address |
| wdata_i | input | 8 | CPU write data |
| sec_tick_i | input | 1 | One-cycle pulse per elapsed second |
| rom_addr_o | output | 21 | Physical ROM byte address |
| ram_addr_o | output | 15 | Physical external RAM byte address |
| ram_cs_o | output | 1 | External RAM selected for this access |
| ext_rdata_o | output | 8 | Read data for the window when RAM is not selected |

## Verification
Every data value from 0 to 255 is written to each of the three decoded control regions. The ROM sweep separates the zero substitution from the bank mask. The enable sweep runs from both the enabled and the disabled state, so a wrongly decoded hold value shows up. The select sweep runs from clock mode, where the five clock codes, the four RAM codes and the ignored codes all give different outputs.

The clock is loaded just below each rollover boundary and then ticked. It also runs 3661 ticks from zero, which tells a missing carry apart from a wrong wrap point. Latch attempts with no preceding 0, or with a stray value in between, check that an unarmed latch takes no snapshot.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int RAM_BANKS = 4;
  localparam int RAM_BW    = $clog2(RAM_BANKS);
  localparam int ROM_OFS_W = 14;
  localparam int RAM_OFS_W = 13;
  localparam int ROM_BANK_W = 7;
  localparam int ROM_AW    = ROM_BANK_W + ROM_OFS_W;
  localparam int RAM_AW    = RAM_BW + RAM_OFS_W;
  localparam int CLK_REGS  = 5;
  localparam int IDX_W     = 3;

  // control region decoded from addr[14:13] when addr[15] is low
  typedef enum logic [1:0] {
    RG_ENABLE = 2'd0,
    RG_ROMSEL = 2'd1,
    RG_SELECT = 2'd2,
    RG_LATCH  = 2'd3
  } ctl_region_e;
endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 128
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [2:0]            region_i,
  input  logic [7:0]            wdata_i,
  output logic                  ram_en_o,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [RAM_BW-1:0]     ram_bank_o,
  output logic                  clk_mode_o,
  output logic [IDX_W-1:0]      clk_idx_o,
  output logic                  latch_o
);
  localparam logic [ROM_BANK_W-1:0] BANK_MASK = ROM_BANK_W'(ROM_BANKS - 1);

  logic        ctl_wr;
  ctl_region_e rg;
  logic [ROM_BANK_W-1:0] bank_nz;
  logic        armed_q;

  assign ctl_wr  = wr_en_i && !region_i[2];
  assign rg      = ctl_region_e'(region_i[1:0]);
  assign bank_nz = (wdata_i[6:0] == '0) ? ROM_BANK_W'(1) : wdata_i[6:0];
  assign latch_o = ctl_wr && rg == RG_LATCH && armed_q && wdata_i == 8'h01;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_en_o   <= 1'b0;
      rom_bank_o <= ROM_BANK_W'(1);
      ram_bank_o <= '0;
      clk_mode_o <= 1'b0;
      clk_idx_o  <= '0;
      armed_q    <= 1'b0;
    end else if (ctl_wr) begin
      unique case (rg)
        RG_ENABLE: begin
          if (wdata_i == 8'h0A)      ram_en_o <= 1'b1;
          else if (wdata_i == 8'h00) ram_en_o <= 1'b0;
        end
        RG_ROMSEL: rom_bank_o <= bank_nz & BANK_MASK;
        RG_SELECT: begin
          if (wdata_i < 8'(RAM_BANKS)) begin
            ram_bank_o <= wdata_i[RAM_BW-1:0];
            clk_mode_o <= 1'b0;
          end else if (wdata_i >= 8'h08 && wdata_i <= 8'h0C) begin
            clk_idx_o  <= wdata_i[IDX_W-1:0] - IDX_W'(0);
            clk_mode_o <= 1'b1;
          end
        end
        RG_LATCH: armed_q <= (wdata_i == 8'h00);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbc_rtc.sv
module cbc_rtc
  import cbc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  input  logic             latch_i,
  output logic [7:0]       rdata_o,
  output logic [5:0]       live_sec_o,
  output logic [7:0]       lat_sec_o
);
  logic [5:0] sec_q, min_q;
  logic [4:0] hr_q;
  logic [8:0] day_q;
  logic [7:0] lat_q [CLK_REGS];

  assign live_sec_o = sec_q;
  assign lat_sec_o  = lat_q[0];

  always_comb begin
    unique case (idx_i)
      3'd0: rdata_o = lat_q[0];
      3'd1: rdata_o = lat_q[1];
      3'd2: rdata_o = lat_q[2];
      3'd3: rdata_o = lat_q[3];
      3'd4: rdata_o = lat_q[4];
      default: rdata_o = 8'hFF;
    endcase
  end

  // live counters: a register write wins over the tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0; day_q <= '0;
    end else if (wr_i) begin
      unique case (idx_i)
        3'd0: sec_q <= wdata_i[5:0];
        3'd1: min_q <= wdata_i[5:0];
        3'd2: hr_q  <= wdata_i[4:0];
        3'd3: day_q[7:0] <= wdata_i;
        3'd4: day_q[8] <= wdata_i[0];
        default: ;
      endcase
    end else if (tick_i) begin
      if (sec_q >= 6'd59) begin
        sec_q <= '0;
        if (min_q >= 6'd59) begin
          min_q <= '0;
          if (hr_q >= 5'd23) begin
            hr_q  <= '0;
            day_q <= day_q + 9'd1;
          end else hr_q <= hr_q + 5'd1;
        end else min_q <= min_q + 6'd1;
      end else sec_q <= sec_q + 6'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CLK_REGS; i++) lat_q[i] <= '0;
    end else if (latch_i) begin
      lat_q[0] <= {2'b0, sec_q};
      lat_q[1] <= {2'b0, min_q};
      lat_q[2] <= {3'b0, hr_q};
      lat_q[3] <= day_q[7:0];
      lat_q[4] <= {lat_q[4][7:1], day_q[8]};
    end else if (wr_i) begin
      unique case (idx_i)
        3'd0: lat_q[0] <= wdata_i;
        3'd1: lat_q[1] <= wdata_i;
        3'd2: lat_q[2] <= wdata_i;
        3'd3: lat_q[3] <= wdata_i;
        3'd4: lat_q[4] <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map
  import cbc_pkg::*;
(
  input  logic [15:0]           addr_i,
  input  logic [ROM_BANK_W-1:0] rom_bank_i,
  input  logic [RAM_BW-1:0]     ram_bank_i,
  input  logic                  ram_en_i,
  input  logic                  clk_mode_i,
  input  logic [7:0]            clk_rdata_i,
  output logic                  ext_win_o,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_cs_o,
  output logic [7:0]            ext_rdata_o
);
  logic [ROM_BANK_W-1:0] eff_bank;

  assign eff_bank    = addr_i[14] ? rom_bank_i : '0;
  assign rom_addr_o  = {eff_bank, addr_i[ROM_OFS_W-1:0]};
  assign ram_addr_o  = {ram_bank_i, addr_i[RAM_OFS_W-1:0]};
  assign ext_win_o   = addr_i[15:13] == 3'b101;
  assign ram_cs_o    = ext_win_o && ram_en_i && !clk_mode_i;
  assign ext_rdata_o = clk_mode_i ? clk_rdata_i : 8'hFF;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              sec_tick_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_cs_o,
  output logic [7:0]        ext_rdata_o
);
  logic                  ram_en, clk_mode, latch_pulse, ext_win, clk_wr;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BW-1:0]     ram_bank;
  logic [IDX_W-1:0]      clk_idx;
  logic [7:0]            clk_rdata, lat_sec;
  logic [5:0]            live_sec;

  assign clk_wr = wr_en_i && ext_win && clk_mode;

  cbc_ctrl_regs #(.ROM_BANKS(ROM_BANKS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i,
    .region_i  (addr_i[15:13]),
    .wdata_i,
    .ram_en_o  (ram_en),
    .rom_bank_o(rom_bank),
    .ram_bank_o(ram_bank),
    .clk_mode_o(clk_mode),
    .clk_idx_o (clk_idx),
    .latch_o   (latch_pulse)
  );

  cbc_rtc u_rtc (
    .clk_i, .rst_ni,
    .tick_i    (sec_tick_i),
    .wr_i      (clk_wr),
    .idx_i     (clk_idx),
    .wdata_i,
    .latch_i   (latch_pulse),
    .rdata_o   (clk_rdata),
    .live_sec_o(live_sec),
    .lat_sec_o (lat_sec)
  );

  cbc_addr_map u_map (
    .addr_i,
    .rom_bank_i (rom_bank),
    .ram_bank_i (ram_bank),
    .ram_en_i   (ram_en),
    .clk_mode_i (clk_mode),
    .clk_rdata_i(clk_rdata),
    .ext_win_o  (ext_win),
    .rom_addr_o,
    .ram_addr_o,
    .ram_cs_o,
    .ext_rdata_o
  );
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
  import cbc_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [15:0]           addr_i,
  input logic [7:0]            wdata_i,
  input logic [ROM_AW-1:0]     rom_addr_o,
  input logic                  ram_cs_o,
  input logic                  ram_en,
  input logic                  clk_mode,
  input logic [ROM_BANK_W-1:0] rom_bank,
  input logic                  latch_pulse,
  input logic [5:0]            live_sec,
  input logic [7:0]            lat_sec
);
  p_enable_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[15:13] == 3'b000 && wdata_i != 8'h00 && wdata_i != 8'h0A)
    |=> $stable(ram_en));

  p_bank_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[15:13] == 3'b001 && wdata_i[6:0] == 7'd0) |=> rom_bank == 7'd1);

  p_fixed_bank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> rom_addr_o[ROM_AW-1:ROM_OFS_W] == '0);

  p_cs_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_cs_o |-> (!clk_mode && ram_en));

  p_latch_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_pulse |=> lat_sec == {2'b00, $past(live_sec)});

  p_sec_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_sec < 6'd59 && !wr_en_i) |=> live_sec < 6'd60);
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rom_addr_o, .ram_cs_o,
  .ram_en, .clk_mode, .rom_bank, .latch_pulse, .live_sec, .lat_sec
);

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, tick = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_cs;
  logic [7:0]  ext_rdata;

  int n_chk = 0, n_err = 0;

  cart_bank_ctrl #(.ROM_BANKS(NBANK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .sec_tick_i(tick), .rom_addr_o(rom_addr), .ram_addr_o(ram_addr),
    .ram_cs_o(ram_cs), .ext_rdata_o(ext_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    addr = a;
    #1;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_latch();
    wr(16'h6000, 8'h00);
    wr(16'h7FFF, 8'h01);
  endtask

  task automatic rd_clk(input int i, output logic [7:0] v);
    wr(16'h4000, 8'(8 + i));
    look(16'hA000);
    v = ext_rdata;
  endtask

  task automatic set_clk(input int i, input logic [7:0] v);
    wr(16'h4000, 8'(8 + i));
    wr(16'hA000, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] lat_exp [5];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    look(16'h4000); check("R11 rom bank", 32'(rom_addr), 32'(21'h1 << 14));
    look(16'hA000); check("R11 ram off", 32'(ram_cs), 0);
    check("R11 ext ff", 32'(ext_rdata), 32'hFF);
    check("R11 ram bank", 32'(ram_addr), 32'h0000);

    // R6 fixed window
    look(16'h0123); check("R6 low window", 32'(rom_addr), 32'h0123);
    look(16'h3FFF); check("R6 low top", 32'(rom_addr), 32'h3FFF);

    // R2 full sweep of ROM bank data
    for (int d = 0; d < 256; d++) begin
      int b;
      b = d & 8'h7F;
      if (b == 0) b = 1;
      b = b & (NBANK - 1);
      wr(16'h2000 + 16'(d * 31), 8'(d));
      look(16'h4000 | 16'(d * 57 & 16'h3FFF));
      check("R2 bank sweep", 32'(rom_addr), 32'((b << 14) | (d * 57 & 16'h3FFF)));
    end
    wr(16'h2000, 8'h05);
    look(16'h7FFF); check("R6 high top", 32'(rom_addr), 32'((5 << 14) | 16'h3FFF));

    // R1 enable sweep from both states
    for (int d = 0; d < 256; d++) begin
      wr(16'h0000, 8'h0A);
      wr(16'h1F00, 8'(d));
      look(16'hA000); check("R1 from enabled", 32'(ram_cs), 32'(d != 0));
      wr(16'h0000, 8'h00);
      wr(16'h0ABC, 8'(d));
      look(16'hBFFF); check("R1 from disabled", 32'(ram_cs), 32'(d == 8'h0A));
    end

    // R10 load latched registers in clock mode
    wr(16'h0000, 8'h0A);
    lat_exp = '{8'h11, 8'h22, 8'h13, 8'h44, 8'hA0};
    for (int i = 0; i < 5; i++) set_clk(i, lat_exp[i]);
    for (int i = 0; i < 5; i++) begin
      rd_clk(i, v); check("R10 latched write", 32'(v), 32'(lat_exp[i]));
    end

    // R3/R4 select sweep starting from clock register 1
    for (int d = 0; d < 256; d++) begin
      wr(16'h4000, 8'h09);
      wr(16'h5000, 8'(d));
      look(16'hA123);
      if (d < 4) begin
        check("R3 ram select cs", 32'(ram_cs), 1);
        check("R3 ram addr", 32'(ram_addr), 32'((d << 13) | 16'h0123));
      end else if (d >= 8 && d <= 12) begin
        check("R4 clock select cs", 32'(ram_cs), 0);
        check("R4 clock reg", 32'(ext_rdata), 32'(lat_exp[d - 8]));
      end else begin
        check("R3 ignored cs", 32'(ram_cs), 0);
        check("R3 ignored reg", 32'(ext_rdata), 32'(lat_exp[1]));
      end
    end

    // R7 disabled RAM outside clock mode
    wr(16'h4000, 8'h02); wr(16'h0000, 8'h00);
    look(16'hA000); check("R7 disabled cs", 32'(ram_cs), 0);
    check("R7 disabled data", 32'(ext_rdata), 32'hFF);
    wr(16'h4000, 8'h0B);
    look(16'hA000); check("R7 clock with ram off", 32'(ext_rdata), 32'h44);
    wr(16'h0000, 8'h0A);

    // R5 latch sequence; live is 17s 34m 19h day 0x44
    ticks(5);
    wr(16'h6000, 8'h01);
    rd_clk(0, v); check("R5 unarmed latch", 32'(v), 32'h11);
    do_latch();
    rd_clk(0, v); check("R5 latch sec", 32'(v), 32'h16);
    rd_clk(1, v); check("R5 latch min", 32'(v), 32'h22);
    rd_clk(2, v); check("R5 latch hr", 32'(v), 32'h13);
    rd_clk(3, v); check("R8 day low", 32'(v), 32'h44);
    rd_clk(4, v); check("R8 reg4 keep", 32'(v), 32'hA0);
    ticks(3);
    wr(16'h6000, 8'h00); wr(16'h6000, 8'h02); wr(16'h6000, 8'h01);
    rd_clk(0, v); check("R5 broken sequence", 32'(v), 32'h16);

    // R8/R9 day bit 8 and full rollover
    set_clk(0, 8'd59); set_clk(1, 8'd59); set_clk(2, 8'd23);
    set_clk(3, 8'hFF); set_clk(4, 8'hA1);
    do_latch();
    rd_clk(4, v); check("R8 day bit8 latched", 32'(v), 32'hA1);
    ticks(1);
    do_latch();
    rd_clk(0, v); check("R9 sec wrap", 32'(v), 0);
    rd_clk(1, v); check("R9 min wrap", 32'(v), 0);
    rd_clk(2, v); check("R9 hr wrap", 32'(v), 0);
    rd_clk(3, v); check("R9 day wrap low", 32'(v), 0);
    rd_clk(4, v); check("R9 day wrap bit8", 32'(v), 32'hA0);

    // R9 carry chain over 3661 seconds
    for (int i = 0; i < 5; i++) set_clk(i, 8'h00);
    ticks(3661);
    do_latch();
    rd_clk(0, v); check("R9 run sec", 32'(v), 1);
    rd_clk(1, v); check("R9 run min", 32'(v), 1);
    rd_clk(2, v); check("R9 run hr", 32'(v), 1);
    rd_clk(3, v); check("R9 run day", 32'(v), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule